// File: doc/BRIEF.md
# Interrupt Latch and Dispatch Sequencer

This block collects interrupt requests and decides when an instruction sequencer may divert into a service routine. Hardware request lines set bits in a pending register. Software can also overwrite that register directly. In each cycle the block picks the lowest-numbered pending bit that is enabled in the mask. It then decides whether dispatch is allowed in that cycle. When it is, the block emits a single-cycle strobe with the chosen index and clears that pending bit.

Dispatch can be withheld by status flags from the pipeline. These flags mark multi-cycle operations: a branch, an uncached fetch that collides with a program-memory data access, particular iterations of short loops, the first fetch of a service routine, and external-memory wait cycles. A request that arrives while one of these is active is still recorded, and only its dispatch is postponed. Software-set bits wait for two completed instructions after the write. Service levels are tracked, so nesting can be switched off or restricted to strictly higher priorities. After any dispatch, one extra cycle must pass before the next dispatch.

Top module: `irq_dispatch_seq`

## Requirements
- R1: A high bit on `irq_req` in a cycle shows as set on `irq_pending` from the next cycle on, whatever the hold flags are, and it stays set until that bit is dispatched.
- R2: With nothing held and nothing in service, a request that is present in cycle c produces `disp_strobe` high for exactly one cycle in cycle c+2. The strobe carries the lowest eligible index on `disp_index`, and that pending bit is cleared. Bit 0 has the highest priority.
- R3: A `sw_wr_en` cycle loads `sw_wr_data` into `irq_pending`, and any hardware requests in that cycle are ORed in. A bit newly set by the write is not dispatched until two cycles with `instr_done` high have followed the write cycle.
- R4: A cycle with `br_active` high blocks dispatch in that cycle and in the next cycle.
- R5: `pm_conflict`, `loop_third_last`, `isr_first_fetch` and `ext_wait` each block dispatch in every cycle in which they are high.
- R6: A cycle with `loop_short_final` high blocks dispatch in that cycle and in the next cycle.
- R7: With `nest_en` low, no dispatch occurs while any service level is active. A level is active from its strobe until it is retired by `rti`.
- R8: With `nest_en` high, a pending bit preempts only if its index is lower than that of every active level. No dispatch ever occurs in the cycle right after a strobe.
- R9: An `rti` pulse retires the active level that has the lowest index.
- R10: After reset, `irq_pending` is zero and `disp_strobe` is low.
- R11: A bit whose `int_mask` bit is 0 is not dispatched and stays pending. With `glob_en` low nothing is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ | Hardware request lines, one per source |
| sw_wr_en | input | 1 | Software write to the pending register |
| sw_wr_data | input | N_IRQ | Value written by software |
| instr_done | input | 1 | An instruction completed this cycle |
| int_mask | input | N_IRQ | Per-source enable (1 = eligible) |
| glob_en | input | 1 | Global dispatch enable |
| nest_en | input | 1 | Allow higher-priority preemption |
| rti | input | 1 | Return-from-interrupt pulse |
| br_active | input | 1 | Branch in this cycle |
| pm_conflict | input | 1 | First cycle of an uncached fetch/data collision |
| loop_third_last | input | 1 | Third-from-last pass of a one-instruction loop |
| loop_short_final | input | 1 | Final pass of a very short loop |
| isr_first_fetch | input | 1 | First of the two cycles fetching a routine's first instruction |
| ext_wait | input | 1 | External-memory wait state |
| disp_strobe | output | 1 | One-cycle dispatch pulse |
| disp_index | output | IDX_W | Index of the dispatched source |
| irq_pending | output | N_IRQ | Pending register contents |

## Verification
The assertions assume that `rti` is pulsed only while some level is in service. They also assume that the hold flags describe the current cycle only, because the block itself stretches the branch and short-loop flags. The stimulus issues `rti` only after a strobe has been observed, and it drives the flags from explicit per-cycle schedules. These schedules are either random with a fixed seed or directed. The expected strobe cycle is then derived from the schedule by the hold rules.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef struct packed {
        logic branch;
        logic pm_conflict;
        logic loop_third_last;
        logic loop_short_final;
        logic isr_first_fetch;
        logic ext_wait;
    } hold_flags_t;

endpackage

// File: rtl/irqd_prio.sv
module irqd_prio #(
    parameter int W    = 8,
    parameter int IW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqd_holdoff.sv
module irqd_holdoff
    import irqd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  hold_flags_t flags,
    output logic        hold
);
    typedef struct packed {
        logic branch_tail;
        logic loop_tail;
    } tail_t;

    tail_t st_d, st_q;

    always_comb begin
        st_d.branch_tail = flags.branch;
        st_d.loop_tail   = flags.loop_short_final;
        hold = flags.branch | st_q.branch_tail
             | flags.loop_short_final | st_q.loop_tail
             | flags.pm_conflict | flags.loop_third_last
             | flags.isr_first_fetch | flags.ext_wait;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_branch_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flags.branch |=> hold);
    assert_loop_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.loop_short_final |=> hold);
    assert_single_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.pm_conflict || flags.ext_wait || flags.isr_first_fetch || flags.loop_third_last) |-> hold);
endmodule

// File: rtl/irqd_latch.sv
module irqd_latch #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_req,
    input  logic          sw_wr_en,
    input  logic [N-1:0]  sw_wr_data,
    input  logic          instr_done,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  sw_blocked
);
    localparam logic [1:0] SETTLE = 2'd2;

    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] sw_mask;
        logic [1:0]   sw_cnt;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [N-1:0] base, clr_vec, sw_new;

    always_comb begin
        st_d    = st_q;
        base    = sw_wr_en ? sw_wr_data : st_q.pend;
        clr_vec = clr_en ? (N'(1) << clr_idx) : '0;
        st_d.pend = (base & ~clr_vec) | irq_req;
        sw_new  = sw_wr_en ? (sw_wr_data & ~st_q.pend & ~irq_req) : '0;
        if (|sw_new) begin
            st_d.sw_cnt  = '0;
            st_d.sw_mask = st_q.sw_mask | sw_new;
        end else if (st_q.sw_cnt != SETTLE && instr_done) begin
            st_d.sw_cnt = st_q.sw_cnt + 2'd1;
            if (st_d.sw_cnt == SETTLE) st_d.sw_mask = '0;
        end
        st_d.sw_mask = st_d.sw_mask & st_d.pend & ~irq_req;
        pend       = st_q.pend;
        sw_blocked = st_q.sw_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend    <= '0;
            st_q.sw_mask <= '0;
            st_q.sw_cnt  <= SETTLE;
        end else begin
            st_q <= st_d;
        end
    end

    assert_req_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> ((st_q.pend & $past(irq_req)) == $past(irq_req)));
    assert_sw_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.sw_mask) |-> (st_q.sw_cnt != SETTLE));
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
    import irqd_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             sw_wr_en,
    input  logic [N_IRQ-1:0] sw_wr_data,
    input  logic             instr_done,
    input  logic [N_IRQ-1:0] int_mask,
    input  logic             glob_en,
    input  logic             nest_en,
    input  logic             rti,
    input  logic             br_active,
    input  logic             pm_conflict,
    input  logic             loop_third_last,
    input  logic             loop_short_final,
    input  logic             isr_first_fetch,
    input  logic             ext_wait,
    output logic             disp_strobe,
    output logic [IDX_W-1:0] disp_index,
    output logic [N_IRQ-1:0] irq_pending
);
    typedef struct packed {
        logic             strobe;
        logic [IDX_W-1:0] idx;
        logic [N_IRQ-1:0] svc;
    } disp_st_t;

    disp_st_t st_d, st_q;

    hold_flags_t      flags;
    logic             hold;
    logic [N_IRQ-1:0] pend, sw_blocked, eligible;
    logic             win_found, svc_found, preempt_ok, go;
    logic [IDX_W-1:0] win_idx, svc_idx;

    assign flags = '{branch: br_active, pm_conflict: pm_conflict,
                     loop_third_last: loop_third_last, loop_short_final: loop_short_final,
                     isr_first_fetch: isr_first_fetch, ext_wait: ext_wait};

    irqd_holdoff u_hold (.clk(clk), .rst_n(rst_n), .flags(flags), .hold(hold));

    irqd_latch #(.N(N_IRQ), .IW(IDX_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .instr_done(instr_done),
        .clr_en(go), .clr_idx(win_idx), .pend(pend), .sw_blocked(sw_blocked));

    assign eligible = pend & int_mask & ~sw_blocked;

    irqd_prio #(.W(N_IRQ), .IW(IDX_W)) u_win (.req(eligible), .found(win_found), .idx(win_idx));
    irqd_prio #(.W(N_IRQ), .IW(IDX_W)) u_svc (.req(st_q.svc), .found(svc_found), .idx(svc_idx));

    always_comb begin
        st_d       = st_q;
        preempt_ok = !svc_found || (nest_en && (win_idx < svc_idx));
        go         = glob_en && win_found && !hold && !st_q.strobe && preempt_ok;
        if (rti && svc_found) st_d.svc[svc_idx] = 1'b0;
        if (go) begin
            st_d.svc[win_idx] = 1'b1;
            st_d.idx          = win_idx;
        end
        st_d.strobe = go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_strobe = st_q.strobe;
    assign disp_index  = st_q.idx;
    assign irq_pending = pend;

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> (!disp_strobe && irq_pending == '0));
    assert_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |-> (($past(eligible) & ((N_IRQ'(1) << disp_index) - N_IRQ'(1))) == '0));
    assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |-> !$past(hold));
    assert_no_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |-> ($past(nest_en) || ($past(st_q.svc) == '0)));
    assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |=> !disp_strobe);
    assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        disp_strobe |-> ($past(glob_en) && $past(int_mask[st_d.idx])));
    assert_rti_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && svc_found && !go) |=> !st_q.svc[$past(svc_idx)]);
endmodule

// File: tb/irq_dispatch_seq_test.sv
module irq_dispatch_seq_test;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] irq_req = '0, sw_wr_data = '0, int_mask = '1;
    logic sw_wr_en = 0, instr_done = 1, glob_en = 1, nest_en = 0, rti = 0;
    logic [5:0] fl = '0;
    logic disp_strobe;
    logic [IW-1:0] disp_index;
    logic [N-1:0] irq_pending;

    int checks = 0, errors = 0;
    logic [5:0] sched [0:23];

    always #2 clk = ~clk;

    irq_dispatch_seq #(.N_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .instr_done(instr_done), .int_mask(int_mask),
        .glob_en(glob_en), .nest_en(nest_en), .rti(rti),
        .br_active(fl[5]), .pm_conflict(fl[4]), .loop_third_last(fl[3]),
        .loop_short_final(fl[2]), .isr_first_fetch(fl[1]), .ext_wait(fl[0]),
        .disp_strobe(disp_strobe), .disp_index(disp_index), .irq_pending(irq_pending));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic nxt;
        @(negedge clk);
    endtask

    function automatic logic [5:0] sf(input int k);
        return (k >= 0 && k < 24) ? sched[k] : 6'd0;
    endfunction

    // earliest decision slot d: bit5 branch and bit2 short-loop also hold the following slot
    function automatic int expect_slot();
        for (int d = 1; d < 40; d++) begin
            logic [5:0] c = sf(d), p = sf(d - 1);
            if (!(c[5] | p[5] | c[2] | p[2] | c[4] | c[3] | c[1] | c[0])) return d;
        end
        return 40;
    endfunction

    task automatic retire;
        rti = 1; nxt; rti = 0; nxt; nxt;
    endtask

    task automatic lat_case(input string req, input int b);
        int exp_k = expect_slot() + 1, got_k = -1, got_idx = -1, n_str = 0;
        nxt; irq_req = N'(1) << b; fl = sched[0];
        for (int k = 1; k <= 44; k++) begin
            nxt;
            if (disp_strobe) begin
                n_str++;
                if (got_k < 0) begin got_k = k; got_idx = disp_index; end
            end
            if (k == 1) chk(irq_pending[b] == 1'b1 || got_k == 1, {req, " R1 latched"}, irq_pending[b], 1);
            irq_req = '0; fl = sf(k);
        end
        chk(got_k == exp_k, {req, " latency"}, got_k, exp_k);
        chk(got_idx == b && n_str == 1, {req, " index/once"}, got_idx, b);
        retire;
    endtask

    task automatic clr_sched;
        for (int i = 0; i < 24; i++) sched[i] = '0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clr_sched;
        nxt; nxt; nxt;
        chk(irq_pending == '0, "R10 pending after reset", irq_pending, 0);
        chk(!disp_strobe, "R10 strobe after reset", disp_strobe, 0);
        rst_n = 1; nxt;

        lat_case("R2 baseline", 4);
        clr_sched; sched[1] = 6'b100000; lat_case("R4 branch", 2);
        clr_sched; sched[1] = 6'b010000; lat_case("R5 pm conflict", 1);
        clr_sched; sched[1] = 6'b001000; lat_case("R5 loop third-last", 3);
        clr_sched; sched[1] = 6'b000010; lat_case("R5 isr fetch", 5);
        clr_sched; for (int i = 1; i < 6; i++) sched[i] = 6'b000001; lat_case("R1 R5 ext wait", 7);
        clr_sched; sched[1] = 6'b000100; lat_case("R6 short loop", 0);

        // R2 R7: two requests, nesting off
        clr_sched;
        nxt; irq_req = 8'b0001_0100;
        nxt; irq_req = '0;
        nxt; chk(disp_strobe && disp_index == 2, "R2 lower index first", disp_index, 2);
        for (int i = 0; i < 5; i++) begin
            nxt; chk(!disp_strobe, "R7 blocked while in service", disp_strobe, 0);
        end
        rti = 1; nxt; rti = 0;
        nxt; chk(disp_strobe && disp_index == 4, "R7 dispatch after rti", disp_index, 4);
        retire;

        // R11 mask and global enable
        int_mask = ~(N'(1) << 6);
        nxt; irq_req = N'(1) << 6;
        nxt; irq_req = '0;
        for (int i = 0; i < 4; i++) begin
            nxt; chk(!disp_strobe && irq_pending[6], "R11 masked stays pending", disp_strobe, 0);
        end
        glob_en = 0; int_mask = '1;
        nxt; nxt; chk(!disp_strobe && irq_pending[6], "R11 global disable", disp_strobe, 0);
        glob_en = 1;
        nxt; chk(disp_strobe && disp_index == 6, "R11 dispatch after enable", disp_index, 6);
        retire;

        // R3 software write, instructions flowing
        nxt; sw_wr_en = 1; sw_wr_data = N'(1) << 3;
        nxt; sw_wr_en = 0;
        chk(irq_pending == (N'(1) << 3), "R3 pending loaded", irq_pending, 8);
        nxt; nxt; chk(!disp_strobe, "R3 early", disp_strobe, 0);
        nxt; chk(disp_strobe && disp_index == 3, "R3 after two instructions", disp_index, 3);
        retire;
        // R3 with instruction stall
        nxt; sw_wr_en = 1; sw_wr_data = N'(1) << 5;
        nxt; sw_wr_en = 0; instr_done = 0;
        nxt; nxt; instr_done = 1;
        nxt; nxt; chk(!disp_strobe, "R3 stalled early", disp_strobe, 0);
        nxt; chk(disp_strobe && disp_index == 5, "R3 stalled dispatch", disp_index, 5);
        retire;

        // R8 R9 nesting
        nest_en = 1;
        nxt; irq_req = N'(1) << 5;
        nxt; irq_req = N'(1) << 1;
        nxt; irq_req = '0;
        chk(disp_strobe && disp_index == 5, "R8 first level", disp_index, 5);
        nxt; chk(!disp_strobe, "R8 deferral cycle", disp_strobe, 0);
        nxt; chk(disp_strobe && disp_index == 1, "R8 preempt", disp_index, 1);
        irq_req = N'(1) << 6;
        nxt; irq_req = '0;
        for (int i = 0; i < 4; i++) begin
            nxt; chk(!disp_strobe, "R8 lower priority waits", disp_strobe, 0);
        end
        rti = 1; nxt; rti = 0;
        nxt; nxt; chk(!disp_strobe && irq_pending[6], "R9 level 5 still active", disp_strobe, 0);
        rti = 1; nxt; rti = 0;
        nxt; chk(disp_strobe && disp_index == 6, "R9 dispatch after both retired", disp_index, 6);
        retire;
        nest_en = 0;

        // random hold schedules
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 24; i++) begin
                logic [5:0] v = '0;
                for (int j = 0; j < 6; j++) v[j] = ($urandom % 7) == 0;
                sched[i] = (i < 12) ? v : 6'd0;
            end
            lat_case("R4 R5 R6 random holds", int'($urandom % N));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule